// File: doc/BRIEF.md
# Dual Alarm Interrupt Controller

This block merges the match strobes of two alarm comparators into a single active-low interrupt line with open-drain drive. Each alarm has an enable bit and a status flag. A flag records every match, whether or not that alarm is enabled. The flags are cleared by a one-cycle strobe that marks the end of a status-register read.

When an enabled alarm matches, the interrupt line is pulled low for a fixed time. That time is a whole number of slow reference ticks, and the ticks are made from the system clock. A mode bit picks between two behaviours:

- **One-shot:** the alarm stops raising pulses after its first one and starts again only when its enable is rewritten.
- **Repeating:** every recurrence of the alarm condition raises a new pulse.

The time comparison and the serial access path are outside the block.

Top module: `dual_alarm_irq`

## Requirements
- R1: After reset, irq_n is 1, irq_oe is 0, both status flags are 0, both alarms are disabled and the mode is one-shot.
- R2: A 1 on match[i] sets flags[i] on the next clock edge, whatever the enable for alarm i. The flag then stays at 1 until it is cleared.
- R3: A 1 on rd_done clears both flags on the next edge. For any alarm whose match is 1 in that same cycle, the match wins and its flag stays at 1.
- R4: cfg_wdata bit 0 enables alarm 0 and bit 1 enables alarm 1 when cfg_we is 1. A match on an alarm whose enable is 0 never pulls irq_n low.
- R5: A qualifying match sampled at a clock edge drives irq_n to 0 and irq_oe to 1 from that edge on. This lasts exactly PULSE_TICKS*TICK_DIV clock cycles, after which irq_n returns to 1. irq_oe is always the inverse of irq_n.
- R6: A qualifying match that arrives while a pulse is active neither stretches nor restarts that pulse.
- R7: cfg_wdata bit 2 at 0 selects one-shot mode. In this mode each qualifying match disarms its alarm. The alarm raises no further pulse until a configuration write sets its enable bit again, although its flag keeps being set.
- R8: cfg_wdata bit 2 at 1 selects repeating mode. In this mode every qualifying match that arrives while no pulse is active starts a new pulse.
- R9: When both enabled alarms match in the same cycle, both flags are set and exactly one pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| match | input | NUM_ALARMS | One-cycle match strobes from the comparator, one per alarm |
| cfg_we | input | 1 | Write strobe for the control field |
| cfg_wdata | input | NUM_ALARMS+1 | Enable bits per alarm; the top bit is the repeat mode |
| rd_done | input | 1 | One-cycle strobe marking a completed status read |
| flags | output | NUM_ALARMS | Sticky alarm status flags |
| irq_n | output | 1 | Interrupt level, active low |
| irq_oe | output | 1 | Open-drain pull-down enable for the interrupt pin |

## Verification
The bench aims at these cases:

- **Match and clear in the same cycle.** A design that let the clear win would lose an alarm event.
- **Matches while a pulse is low.** A design that restarted its timer would give a stretched pulse.
- **Repeat matches in one-shot mode.** A design that forgot to disarm would raise a second pulse.
- **A match on a disabled alarm.** A design that gated the flag with the enable would leave the flag clear.
- **Two alarms matching together.** This must give one pulse, not two back to back.

Pulse width is compared cycle by cycle, so an off-by-one in the tick prescaler or the tick counter shows up as a pulse one cycle or one tick too long or too short.

// File: rtl/aic_pkg.sv
package aic_pkg;

  // Total low time of the interrupt in clock cycles.
  function automatic int unsigned pulse_cycles(input int unsigned div,
                                               input int unsigned ticks);
    return div * ticks;
  endfunction

  // Sticky flag: a set request beats a clear request.
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Arm state after one cycle when no configuration write happens.
  function automatic logic arm_next(input logic armed, input logic hit,
                                    input logic repeat_mode);
    return armed & ~(hit & ~repeat_mode);
  endfunction

endpackage

// File: rtl/aic_flag_bank.sv
module aic_flag_bank #(
  parameter int NUM_ALARMS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_ALARMS-1:0] match,
  input  logic                  rd_done,
  output logic [NUM_ALARMS-1:0] flag_q
);
  import aic_pkg::*;

  for (genvar gi = 0; gi < NUM_ALARMS; gi++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[gi] <= 1'b0;
      else        flag_q[gi] <= flag_next(flag_q[gi], match[gi], rd_done);
    end
  end
endmodule

// File: rtl/aic_arm_ctl.sv
module aic_arm_ctl #(
  parameter int NUM_ALARMS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_ALARMS-1:0] match,
  input  logic                  cfg_we,
  input  logic [NUM_ALARMS:0]   cfg_wdata,
  output logic [NUM_ALARMS-1:0] hit,
  output logic [NUM_ALARMS-1:0] armed_q,
  output logic                  repeat_q
);
  import aic_pkg::*;

  localparam int ModeBit = NUM_ALARMS;

  // A match qualifies only while its alarm is armed; armed implies enabled.
  assign hit = match & armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      repeat_q <= 1'b0;
    else if (cfg_we) repeat_q <= cfg_wdata[ModeBit];
  end

  for (genvar gi = 0; gi < NUM_ALARMS; gi++) begin : g_arm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      armed_q[gi] <= 1'b0;
      else if (cfg_we) armed_q[gi] <= cfg_wdata[gi];
      else             armed_q[gi] <= arm_next(armed_q[gi], hit[gi], repeat_q);
    end
  end
endmodule

// File: rtl/aic_pulse_timer.sv
module aic_pulse_timer #(
  parameter int TICK_DIV    = 50000,
  parameter int PULSE_TICKS = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic start,
  output logic active_q
);
  localparam int DivW  = (TICK_DIV    > 1) ? $clog2(TICK_DIV)    : 1;
  localparam int TickW = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  localparam logic [DivW-1:0]  DivLast  = DivW'(TICK_DIV - 1);
  localparam logic [TickW-1:0] TickLast = TickW'(PULSE_TICKS - 1);

  logic [DivW-1:0]  div_q;
  logic [TickW-1:0] tick_q;
  logic             tick_evt;
  logic             last_tick;

  // Triggers during an active pulse are dropped, never restarting it.
  assign start     = trig & ~active_q;
  assign tick_evt  = active_q & (div_q == DivLast);
  assign last_tick = tick_evt & (tick_q == TickLast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      div_q    <= '0;
      tick_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      div_q    <= '0;
      tick_q   <= '0;
    end else if (active_q) begin
      if (tick_evt) begin
        div_q <= '0;
        if (last_tick) active_q <= 1'b0;
        else           tick_q   <= tick_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dual_alarm_irq.sv
module dual_alarm_irq #(
  parameter int NUM_ALARMS  = 2,
  parameter int TICK_DIV    = 50000,
  parameter int PULSE_TICKS = 25
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_ALARMS-1:0] match,
  input  logic                  cfg_we,
  input  logic [NUM_ALARMS:0]   cfg_wdata,
  input  logic                  rd_done,
  output logic [NUM_ALARMS-1:0] flags,
  output logic                  irq_n,
  output logic                  irq_oe
);
  logic [NUM_ALARMS-1:0] hit;
  logic [NUM_ALARMS-1:0] armed_q;
  logic                  repeat_q;
  logic                  any_hit;
  logic                  pulse_start;
  logic                  pulse_active;

  aic_flag_bank #(.NUM_ALARMS(NUM_ALARMS)) flags_i (
    .clk(clk), .rst_n(rst_n), .match(match), .rd_done(rd_done),
    .flag_q(flags)
  );

  aic_arm_ctl #(.NUM_ALARMS(NUM_ALARMS)) arm_i (
    .clk(clk), .rst_n(rst_n), .match(match), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .hit(hit), .armed_q(armed_q), .repeat_q(repeat_q)
  );

  // Simultaneous hits fold into one trigger.
  assign any_hit = |hit;

  aic_pulse_timer #(.TICK_DIV(TICK_DIV), .PULSE_TICKS(PULSE_TICKS)) timer_i (
    .clk(clk), .rst_n(rst_n), .trig(any_hit),
    .start(pulse_start), .active_q(pulse_active)
  );

  assign irq_n  = ~pulse_active;
  assign irq_oe = pulse_active;
endmodule

// File: rtl/aic_checker.sv
module aic_checker #(
  parameter int NUM_ALARMS = 2,
  parameter int WIDTH      = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_ALARMS-1:0] match,
  input logic                  rd_done,
  input logic [NUM_ALARMS-1:0] flags,
  input logic [NUM_ALARMS-1:0] armed_q,
  input logic                  irq_n,
  input logic                  irq_oe
);
  int unsigned low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     low_cnt <= 0;
    else if (irq_n) low_cnt <= 0;
    else            low_cnt <= low_cnt + 1;
  end

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match[0] |=> flags[0]);

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !match[0]) |=> !flags[0]);

  // R3
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(match[0]));

  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(|(match & armed_q)));

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> (low_cnt == WIDTH));

  // R6
  no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (low_cnt < WIDTH));

  // R5
  oe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe == !irq_n);
endmodule

bind dual_alarm_irq aic_checker #(
  .NUM_ALARMS(NUM_ALARMS),
  .WIDTH(PULSE_TICKS * TICK_DIV)
) chk_i (
  .clk(clk), .rst_n(rst_n), .match(match), .rd_done(rd_done),
  .flags(flags), .armed_q(armed_q), .irq_n(irq_n), .irq_oe(irq_oe)
);

// File: tb/dual_alarm_irq_tb.sv
module dual_alarm_irq_tb_top;
  localparam int TD = 3;
  localparam int PT = 4;
  localparam int W  = TD * PT;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] match = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic       rd_done = 1'b0;
  logic [1:0] flags;
  logic       irq_n;
  logic       irq_oe;

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;

  // reference model state
  bit [1:0] m_flags = '0;
  bit [1:0] m_armed = '0;
  bit       m_rpt   = 1'b0;
  int       m_left  = 0;
  int       pulses  = 0;

  always #10 clk = ~clk;

  dual_alarm_irq #(.NUM_ALARMS(2), .TICK_DIV(TD), .PULSE_TICKS(PT)) dut_i (
    .clk(clk), .rst_n(rst_n), .match(match), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .rd_done(rd_done), .flags(flags),
    .irq_n(irq_n), .irq_oe(irq_oe)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    check({tag, " flags"}, flags, m_flags);
    check({tag, " irq_n"}, irq_n, (m_left > 0) ? 0 : 1);
    check({tag, " irq_oe R5"}, irq_oe, (m_left > 0) ? 1 : 0);
  endtask

  task automatic step(input bit [1:0] m, input bit we, input bit [2:0] wd,
                      input bit rd, input string tag);
    bit [1:0] q;
    match = m; cfg_we = we; cfg_wdata = wd; rd_done = rd;
    @(posedge clk);
    for (int i = 0; i < 2; i++) if (m[i]) m_flags[i] = 1'b1;
      else if (rd) m_flags[i] = 1'b0;
    q = m & m_armed;
    if (we) begin
      m_armed = wd[1:0];
    end else if (!m_rpt) begin
      m_armed = m_armed & ~q;
    end
    if (we) m_rpt = wd[2];
    if (m_left > 0) m_left--;
    else if (q != 0) begin
      m_left = W;
      pulses++;
    end
    @(negedge clk);
    match = '0; cfg_we = 1'b0; rd_done = 1'b0;
    compare_all(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(2'b00, 1'b0, 3'b000, 1'b0, tag);
  endtask

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after release");

    // match on disabled alarm: flag only
    step(2'b01, 0, 3'b000, 0, "R2 R4 disabled match");
    idle(3, "R4 no pulse");
    step(2'b00, 0, 3'b000, 1, "R3 read clears");
    step(2'b10, 0, 3'b000, 0, "R2 set alarm1");
    step(2'b10, 0, 3'b000, 1, "R3 match beats clear");
    step(2'b01, 0, 3'b000, 1, "R3 clear1 set0");
    step(2'b00, 0, 3'b000, 1, "R3 clear all");

    // one-shot, alarm 0 enabled
    step(2'b00, 1, 3'b001, 0, "R4 cfg en0");
    step(2'b10, 0, 3'b000, 0, "R4 match on disabled alarm1");
    idle(2, "R4 idle");
    p0 = pulses;
    step(2'b01, 0, 3'b000, 0, "R5 start pulse");
    idle(W + 2, "R5 width");
    check("R5 one pulse", pulses - p0, 1);
    p0 = pulses;
    step(2'b01, 0, 3'b000, 0, "R7 oneshot rematch");
    idle(W + 2, "R7 stays high");
    check("R7 no second pulse", pulses - p0, 0);
    check("R7 irq still high", irq_n, 1);

    // rewrite re-arms
    step(2'b00, 1, 3'b001, 0, "R7 rearm");
    step(2'b01, 0, 3'b000, 0, "R7 pulse after rearm");
    idle(3, "R6 mid pulse");
    step(2'b01, 0, 3'b000, 0, "R6 match in pulse");
    idle(W + 2, "R6 no stretch");

    // repeating mode, both enabled
    step(2'b00, 1, 3'b111, 1, "R8 cfg repeat");
    p0 = pulses;
    for (int k = 0; k < 3; k++) begin
      step(2'b10, 0, 3'b000, 0, "R8 recur");
      idle(W + 3, "R8 gap");
    end
    check("R8 three pulses", pulses - p0, 3);
    p0 = pulses;
    step(2'b11, 0, 3'b000, 0, "R9 both match");
    check("R9 both flags", flags, 3);
    idle(W + 2, "R9 one pulse");
    check("R9 single pulse", pulses - p0, 1);
    step(2'b01, 0, 3'b000, 0, "R8 back-to-back a");
    idle(W - 1, "R8 wait");
    step(2'b01, 0, 3'b000, 0, "R6 match on last low cycle");
    step(2'b01, 0, 3'b000, 0, "R8 restart after end");
    idle(W + 2, "R8 tail");

    // disable alarm 1 only
    step(2'b00, 1, 3'b101, 1, "R4 en0 only repeat");
    step(2'b10, 0, 3'b000, 0, "R4 alarm1 off");
    idle(3, "R4 still high");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule